// File: doc/BRIEF.md
# Tuner Configuration Register Slave on a Two-Wire Bus

This block is a two-wire serial slave that holds the configuration bytes of an RF tuner together with two bytes of status readback. SCL and SDA are oversampled on a fast system clock, and the block detects START, repeated START and STOP on its own. It answers one 7-bit device address, whose lowest bit comes from a board strap. The first byte after a write address selects a register. Further bytes are either written to consecutive registers, or read back after a repeated START with a read address.

Every writable byte is driven out in parallel to the analog and synthesizer control logic. Writing the byte that completes the fractional divider word (register 4) fires a single-cycle pulse that starts the oscillator band search. The status byte at register 12 carries a power-on flag. The flag stays set from reset until a STOP that follows a read of that byte. The SDA pad is modelled as an open-drain enable that, when high, pulls the line low.

Top module: `tuner_cfg_i2c_slave`

## Requirements
- R1: The block acknowledges the device address 110000s, where s is `addr_strap_i` (bytes 0xC0/0xC1 for strap 0, 0xC2/0xC3 for strap 1). Any other address is not acknowledged, and SDA stays released for the rest of that transfer, up to the next START.
- R2: After reset, registers 0 to 11 hold 0x80, 0x23, 0x02, 0xF6, 0x84, 0x01, 0xC0, 0xCC, 0x4B, 0x00, 0x00, 0x08. `sda_oe_o` is low, `por_flag_o` is high and `vco_sel_start_o` is low.
- R3: In a write transfer, the byte after the address sets the register pointer. Each following byte, received MSB first, goes to the pointed register, and the pointer then advances. The slave pulls SDA low in the ninth clock of every byte it accepts. Registers change only through such writes.
- R4: A repeated START with a read address returns the pointed register MSB first, and the pointer then advances. A master ACK makes the slave send the next register. A master NACK makes it release SDA until the next START or STOP.
- R5: Register 12 reads as {power-on flag, `stat_live_i`[6:0]` } and register 13 reads as `stat_band_i`. Data bytes written to 12 or 13 are acknowledged and then dropped, and the pointer still advances.
- R6: The pointer advances from 13 back to 0, both on writes and on reads.
- R7: The power-on flag is cleared only by a STOP that follows a read of register 12 in the same transfer. Without a STOP it stays set, and it is never set again except by reset.
- R8: `vco_sel_start_o` pulses high for exactly one cycle for each data byte written to register 4, and never for any other register.
- R9: A START in the middle of a byte drops that byte and restarts address reception. After a STOP, clock pulses with no START write nothing and are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_strap_i | input | 1 | Strap that sets the lowest device address bit |
| stat_live_i | input | 7 | Live status bits shown in register 12, bits 6:0 |
| stat_band_i | input | 8 | Status byte shown as register 13 |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |
| cfg_regs_o | output | 96 | Writable registers, register k at bits 8k+7:8k |
| por_flag_o | output | 1 | Power-on flag (register 12, bit 7) |
| vco_sel_start_o | output | 1 | One-cycle pulse after a write to register 4 |

## Verification
The bench builds the block with its default parameters: twelve writable bytes plus two status bytes, a two-flop synchronizer, the strobe on register 4, and the base address 110000. It drives the strap both ways, so both device addresses are reached. With fourteen registers, a short burst started at 12 or 13 crosses the wrap from 13 to 0 on both the write and the read path. The power-on flag is read before its STOP and again after it.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;

   localparam int BYTE_W = 8;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_ACK,
      PH_TX,
      PH_MACK,
      PH_WAIT
   } phase_e;

   typedef enum logic [1:0] {
      RX_DEVADDR,
      RX_POINTER,
      RX_DATA
   } rxkind_e;

   // power-up contents of the writable configuration bytes
   function automatic byte_t reg_default(input int idx);
      case (idx)
         0:       return 8'h80;
         1:       return 8'h23;
         2:       return 8'h02;
         3:       return 8'hF6;
         4:       return 8'h84;
         5:       return 8'h01;
         6:       return 8'hC0;
         7:       return 8'hCC;
         8:       return 8'h4B;
         11:      return 8'h08;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/tcfg_bus_sync.sv
module tcfg_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_d;
   logic              sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_lvl   = scl_pipe[STAGES-1];
   assign sda_lvl   = sda_pipe[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   // data edges while the clock line stays high are framing conditions
   assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/tcfg_link_fsm.sv
module tcfg_link_fsm
   import tcfg_pkg::*;
#(
   parameter logic [5:0] DEV_ADDR_HI = 6'b110000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  scl_rise,
   input  logic  scl_fall,
   input  logic  start_evt,
   input  logic  stop_evt,
   input  logic  sda_lvl,
   input  logic  addr_lsb,
   input  byte_t rd_data,
   output logic  sda_oe,
   output logic  ptr_load,
   output logic  wr_en,
   output byte_t rx_byte,
   output logic  rd_adv
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   phase_e           ph_q;
   rxkind_e          kind_q;
   logic [CNT_W-1:0] cnt_q;
   byte_t            sh_q;
   byte_t            tx_q;
   logic             rw_q;
   logic             mack_q;
   logic             oe_q;
   logic             rx_done;
   logic             addr_hit;

   always_comb begin
      rx_done  = (ph_q == PH_RX) && scl_fall && (cnt_q == CNT_FULL);
      addr_hit = (sh_q[BYTE_W-1:1] == {DEV_ADDR_HI, addr_lsb});
      ptr_load = rx_done && (kind_q == RX_POINTER);
      wr_en    = rx_done && (kind_q == RX_DATA);
      rd_adv   = scl_fall &&
                 (((ph_q == PH_ACK) && (kind_q == RX_DEVADDR) && rw_q) ||
                  ((ph_q == PH_MACK) && !mack_q));
   end

   assign rx_byte = sh_q;
   assign sda_oe  = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         kind_q <= RX_DEVADDR;
         cnt_q  <= '0;
         sh_q   <= '0;
         tx_q   <= '0;
         rw_q   <= 1'b0;
         mack_q <= 1'b1;
         oe_q   <= 1'b0;
      end else if (start_evt) begin
         ph_q   <= PH_RX;
         kind_q <= RX_DEVADDR;
         cnt_q  <= '0;
         oe_q   <= 1'b0;
      end else if (stop_evt) begin
         ph_q <= PH_IDLE;
         oe_q <= 1'b0;
      end else begin
         case (ph_q)
            PH_RX: begin
               if (scl_rise && (cnt_q != CNT_FULL)) begin
                  sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
                  cnt_q <= cnt_q + 1'b1;
               end else if (rx_done) begin
                  if ((kind_q == RX_DEVADDR) && !addr_hit) begin
                     ph_q <= PH_WAIT;
                  end else begin
                     ph_q <= PH_ACK;
                     oe_q <= 1'b1;
                  end
                  if (kind_q == RX_DEVADDR) rw_q <= sh_q[0];
               end
            end
            PH_ACK: begin
               if (scl_fall) begin
                  cnt_q <= '0;
                  if ((kind_q == RX_DEVADDR) && rw_q) begin
                     ph_q <= PH_TX;
                     tx_q <= rd_data;
                     oe_q <= ~rd_data[BYTE_W-1];
                  end else begin
                     ph_q   <= PH_RX;
                     oe_q   <= 1'b0;
                     kind_q <= (kind_q == RX_DEVADDR) ? RX_POINTER : RX_DATA;
                  end
               end
            end
            PH_TX: begin
               if (scl_fall) begin
                  if (cnt_q == CNT_LAST) begin
                     ph_q <= PH_MACK;
                     oe_q <= 1'b0;
                  end else begin
                     tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                     oe_q  <= ~tx_q[BYTE_W-2];
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            PH_MACK: begin
               if (scl_rise) mack_q <= sda_lvl;
               if (scl_fall) begin
                  if (!mack_q) begin
                     ph_q  <= PH_TX;
                     tx_q  <= rd_data;
                     oe_q  <= ~rd_data[BYTE_W-1];
                     cnt_q <= '0;
                  end else begin
                     ph_q <= PH_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/tcfg_regbank.sv
module tcfg_regbank
   import tcfg_pkg::*;
#(
   parameter int NUM_WR    = 12,
   parameter int NUM_REGS  = 14,
   parameter int PTR_W     = 4,
   parameter int STRB_IDX  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ptr_load,
   input  logic                     wr_en,
   input  logic                     rd_adv,
   input  logic                     stop_evt,
   input  byte_t                    rx_byte,
   input  logic [BYTE_W-2:0]        stat_live,
   input  byte_t                    stat_band,
   output byte_t                    rd_data,
   output logic [NUM_WR*BYTE_W-1:0] cfg_flat,
   output logic [PTR_W-1:0]         ptr,
   output logic                     por_flag,
   output logic                     strobe
);

   localparam int                 POR_IDX  = NUM_WR;
   localparam int                 BAND_IDX = NUM_WR + 1;
   localparam logic [PTR_W-1:0]   PTR_TOP  = PTR_W'(NUM_REGS - 1);

   byte_t            regs_q [NUM_WR];
   logic [PTR_W-1:0] ptr_q;
   logic             por_q;
   logic             seen_q;
   logic             strb_q;

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      return (p == PTR_TOP) ? '0 : p + 1'b1;
   endfunction

   generate
      for (genvar r = 0; r < NUM_WR; r++) begin : g_cfg
         localparam byte_t RST_VAL = reg_default(r);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                regs_q[r] <= RST_VAL;
            else if (wr_en && (ptr_q == PTR_W'(r)))    regs_q[r] <= rx_byte;
         end
         assign cfg_flat[r*BYTE_W +: BYTE_W] = regs_q[r];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_WR; k++) begin
         if (ptr_q == PTR_W'(k)) rd_data = regs_q[k];
      end
      if (ptr_q == PTR_W'(POR_IDX))  rd_data = {por_q, stat_live};
      if (ptr_q == PTR_W'(BAND_IDX)) rd_data = stat_band;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         por_q  <= 1'b1;
         seen_q <= 1'b0;
         strb_q <= 1'b0;
      end else begin
         if (ptr_load)              ptr_q <= (rx_byte < BYTE_W'(NUM_REGS)) ? rx_byte[PTR_W-1:0] : '0;
         else if (wr_en || rd_adv)  ptr_q <= ptr_next(ptr_q);

         if (rd_adv && (ptr_q == PTR_W'(POR_IDX))) begin
            seen_q <= 1'b1;
         end else if (stop_evt) begin
            seen_q <= 1'b0;
            if (seen_q) por_q <= 1'b0;
         end

         strb_q <= wr_en && (ptr_q == PTR_W'(STRB_IDX));
      end
   end

   assign ptr      = ptr_q;
   assign por_flag = por_q;
   assign strobe   = strb_q;

endmodule

// File: rtl/tuner_cfg_i2c_slave.sv
module tuner_cfg_i2c_slave
   import tcfg_pkg::*;
#(
   parameter int         NUM_WR      = 12,
   parameter int         NUM_RO      = 2,
   parameter int         SYNC_STAGES = 2,
   parameter int         STROBE_REG  = 4,
   parameter logic [5:0] DEV_ADDR_HI = 6'b110000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scl_i,
   input  logic                     sda_i,
   input  logic                     addr_strap_i,
   input  logic [BYTE_W-2:0]        stat_live_i,
   input  logic [BYTE_W-1:0]        stat_band_i,
   output logic                     sda_oe_o,
   output logic [NUM_WR*BYTE_W-1:0] cfg_regs_o,
   output logic                     por_flag_o,
   output logic                     vco_sel_start_o
);

   localparam int NUM_REGS = NUM_WR + NUM_RO;
   localparam int PTR_W    = $clog2(NUM_REGS);
   localparam int CFG_W    = NUM_WR * BYTE_W;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (NUM_RO != 2) begin : g_bad_ro
         $error("exactly two status bytes are supported");
      end
      if (STROBE_REG >= NUM_WR) begin : g_bad_strobe
         $error("STROBE_REG must name a writable register");
      end
      if (NUM_REGS > 256) begin : g_bad_count
         $error("register count exceeds a one-byte pointer");
      end
   endgenerate

   logic             scl_lvl;
   logic             sda_lvl;
   logic             scl_rise;
   logic             scl_fall;
   logic             start_evt;
   logic             stop_evt;
   logic             ptr_load;
   logic             wr_en;
   logic             rd_adv;
   byte_t            rx_byte;
   byte_t            rd_data;
   logic [PTR_W-1:0] cur_ptr;

   tcfg_bus_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   tcfg_link_fsm #(
      .DEV_ADDR_HI (DEV_ADDR_HI)
   ) i_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt),
      .sda_lvl   (sda_lvl),
      .addr_lsb  (addr_strap_i),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe_o),
      .ptr_load  (ptr_load),
      .wr_en     (wr_en),
      .rx_byte   (rx_byte),
      .rd_adv    (rd_adv)
   );

   tcfg_regbank #(
      .NUM_WR   (NUM_WR),
      .NUM_REGS (NUM_REGS),
      .PTR_W    (PTR_W),
      .STRB_IDX (STROBE_REG)
   ) i_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr_load  (ptr_load),
      .wr_en     (wr_en),
      .rd_adv    (rd_adv),
      .stop_evt  (stop_evt),
      .rx_byte   (rx_byte),
      .stat_live (stat_live_i),
      .stat_band (stat_band_i),
      .rd_data   (rd_data),
      .cfg_flat  (cfg_regs_o),
      .ptr       (cur_ptr),
      .por_flag  (por_flag_o),
      .strobe    (vco_sel_start_o)
   );

endmodule

// File: rtl/tcfg_chk.sv
module tcfg_chk #(
   parameter int CFG_W    = 96,
   parameter int PTR_W    = 4,
   parameter int NUM_REGS = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_lvl,
   input logic             sda_oe,
   input logic             stop_evt,
   input logic             wr_en,
   input logic             strobe,
   input logic             por,
   input logic [CFG_W-1:0] cfg,
   input logic [PTR_W-1:0] ptr
);

   // R8
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

   // R8
   strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> $past(wr_en));

   // R3
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable(cfg));

   // R3
   oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_lvl);

   // R7
   por_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(por));

   // R7
   por_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(por) |-> $past(stop_evt));

   // R9
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe);

   // R6
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PTR_W'(NUM_REGS - 1));

endmodule

bind tuner_cfg_i2c_slave tcfg_chk #(
   .CFG_W    (CFG_W),
   .PTR_W    (PTR_W),
   .NUM_REGS (NUM_REGS)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_lvl  (scl_lvl),
   .sda_oe   (sda_oe_o),
   .stop_evt (stop_evt),
   .wr_en    (wr_en),
   .strobe   (vco_sel_start_o),
   .por      (por_flag_o),
   .cfg      (cfg_regs_o),
   .ptr      (cur_ptr)
);

// File: tb/test_tuner_cfg_i2c_slave.sv
`timescale 1ns/1ps
module test_tuner_cfg_i2c_slave;

   localparam int Q = 5;
   localparam int H = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        strap = 1'b0;
   logic [6:0]  stat_live = 7'h25;
   logic [7:0]  stat_band = 8'h9B;
   logic        sda_oe;
   logic [95:0] cfg;
   logic        por;
   logic        strb;
   logic        sda_bus;

   int n_cmp = 0;
   int n_bad = 0;
   int strb_cyc = 0;
   int strb_pulses = 0;
   logic strb_prev = 1'b0;

   logic [7:0] mdl [12];
   logic [7:0] wbuf [8];
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] obs_val;
   event       obs_ev;

   always #2.5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   tuner_cfg_i2c_slave i_tuner_cfg_i2c_slave (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (scl_m),
      .sda_i           (sda_bus),
      .addr_strap_i    (strap),
      .stat_live_i     (stat_live),
      .stat_band_i     (stat_band),
      .sda_oe_o        (sda_oe),
      .cfg_regs_o      (cfg),
      .por_flag_o      (por),
      .vco_sel_start_o (strb)
   );

   always @(posedge clk) begin
      if (strb) strb_cyc++;
      if (strb && !strb_prev) strb_pulses++;
      strb_prev = strb;
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string rq, input string what);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // monitor side of the scoreboard
   initial begin
      forever begin
         @(obs_ev);
         if (exp_q.size() == 0) begin
            chk(obs_val, 32'hFFFF, "R4", "unexpected read byte");
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(obs_val, e, t, "read byte");
         end
      end
   end

   task automatic push_exp(input logic [7:0] v, input string rq);
      exp_q.push_back(v);
      tag_q.push_back(rq);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bits(input logic [7:0] v, input int nb);
      for (int b = 7; b > 7 - nb; b--) begin
         sda_m = v[b]; tick(Q);
         scl_m = 1'b1; tick(H);
         scl_m = 1'b0; tick(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      send_bits(v, 8);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(H/2);
      ack = sda_bus; tick(H/2);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic nack);
      v = '0;
      for (int b = 0; b < 8; b++) begin
         sda_m = 1'b1; tick(Q);
         scl_m = 1'b1; tick(H/2);
         v = {v[6:0], sda_bus}; tick(H/2);
         scl_m = 1'b0; tick(Q);
      end
      sda_m = nack; tick(Q);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   task automatic write_txn(input logic [6:0] dev, input logic [7:0] ptr, input int n,
                            input logic exp_bit, input string rq);
      logic a;
      bus_start();
      send_byte({dev, 1'b0}, a); chk(a, exp_bit, rq, "address ack bit");
      send_byte(ptr, a);         chk(a, exp_bit, rq, "pointer ack bit");
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], a);  chk(a, exp_bit, rq, "data ack bit");
      end
      bus_stop();
   endtask

   task automatic read_txn(input logic [6:0] dev, input logic [7:0] ptr, input int n,
                           input logic do_stop, input string rq);
      logic       a;
      logic [7:0] v;
      bus_start();
      send_byte({dev, 1'b0}, a); chk(a, 0, rq, "address ack");
      send_byte(ptr, a);         chk(a, 0, rq, "pointer ack");
      bus_start();
      send_byte({dev, 1'b1}, a); chk(a, 0, rq, "read address ack");
      for (int i = 0; i < n; i++) begin
         recv_byte(v, (i == n - 1));
         obs_val = v;
         -> obs_ev;
         tick(1);
      end
      chk(sda_oe, 0, "R4", "SDA released after NACK");
      if (do_stop) bus_stop();
   endtask

   task automatic check_cfg(input string rq);
      for (int r = 0; r < 12; r++) begin
         chk(cfg[r*8 +: 8], mdl[r], rq, $sformatf("register %0d", r));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic a;
      int   p0;
      int   c0;
      mdl = '{8'h80, 8'h23, 8'h02, 8'hF6, 8'h84, 8'h01, 8'hC0, 8'hCC, 8'h4B, 8'h00, 8'h00, 8'h08};

      tick(8);
      rst_n = 1'b1;
      tick(4);
      // R2 reset state
      chk(sda_oe, 0, "R2", "sda_oe after reset");
      chk(por, 1, "R2", "power-on flag after reset");
      chk(strb, 0, "R2", "strobe after reset");
      check_cfg("R2");

      // R3 write burst, strap 0 address 0x60
      wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
      write_txn(7'h60, 8'h08, 2, 1'b0, "R3");
      mdl[8] = 8'h5A; mdl[9] = 8'hA5;
      check_cfg("R3");

      // R4 read burst with repeated START
      push_exp(8'h5A, "R4"); push_exp(8'hA5, "R4"); push_exp(8'h00, "R4");
      read_txn(7'h60, 8'h08, 3, 1'b1, "R4");

      // R1 wrong address with strap 0: no ack, SDA untouched afterwards
      wbuf[0] = 8'hEE;
      write_txn(7'h61, 8'h00, 1, 1'b1, "R1");
      check_cfg("R1");

      // R1 strap 1 selects 0x61
      strap = 1'b1; tick(4);
      write_txn(7'h60, 8'h0A, 1, 1'b1, "R1");
      wbuf[0] = 8'h3C;
      write_txn(7'h61, 8'h0A, 1, 1'b0, "R1");
      mdl[10] = 8'h3C;
      check_cfg("R1");

      // R8 strobe on register 4 only
      p0 = strb_pulses; c0 = strb_cyc;
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      write_txn(7'h61, 8'h03, 3, 1'b0, "R8");
      mdl[3] = 8'h11; mdl[4] = 8'h22; mdl[5] = 8'h33;
      chk(strb_pulses - p0, 1, "R8", "pulses for burst over 3..5");
      chk(strb_cyc - c0, 1, "R8", "strobe high cycles");
      p0 = strb_pulses;
      wbuf[0] = 8'h44; wbuf[1] = 8'h55;
      write_txn(7'h61, 8'h04, 2, 1'b0, "R8");
      mdl[4] = 8'h44; mdl[5] = 8'h55;
      chk(strb_pulses - p0, 1, "R8", "pulses for burst over 4..5");
      p0 = strb_pulses;
      wbuf[0] = 8'h66;
      write_txn(7'h61, 8'h06, 1, 1'b0, "R8");
      mdl[6] = 8'h66;
      chk(strb_pulses - p0, 0, "R8", "pulses for write to 6");
      check_cfg("R8");

      // R7 flag survives transfers without a status read
      chk(por, 1, "R7", "flag before status read");
      push_exp({1'b1, 7'h25}, "R5"); push_exp(8'h9B, "R5");
      read_txn(7'h61, 8'h0C, 2, 1'b0, "R7");
      chk(por, 1, "R7", "flag before STOP");
      bus_stop(); tick(4);
      chk(por, 0, "R7", "flag after STOP");
      stat_live = 7'h5A; tick(2);
      push_exp({1'b0, 7'h5A}, "R7");
      read_txn(7'h61, 8'h0C, 1, 1'b1, "R7");
      chk(por, 0, "R7", "flag stays clear");

      // R5 and R6 writes to status bytes dropped, pointer wraps to 0
      wbuf[0] = 8'hFF; wbuf[1] = 8'hEE; wbuf[2] = 8'h77;
      write_txn(7'h61, 8'h0C, 3, 1'b0, "R5");
      mdl[0] = 8'h77;
      check_cfg("R6");
      push_exp(8'h9B, "R5"); push_exp(8'h77, "R6"); push_exp(8'h23, "R6");
      read_txn(7'h61, 8'h0D, 3, 1'b1, "R6");

      // R9 START inside a byte discards it
      bus_start();
      send_byte(8'hC2, a); chk(a, 0, "R9", "address ack");
      send_byte(8'h02, a); chk(a, 0, "R9", "pointer ack");
      send_bits(8'hF0, 4);
      wbuf[0] = 8'h99;
      write_txn(7'h61, 8'h02, 1, 1'b0, "R9");
      mdl[2] = 8'h99;
      check_cfg("R9");

      // R9 bytes clocked after STOP without START are ignored
      send_byte(8'hC2, a); chk(a, 1, "R9", "ack bit while idle");
      send_byte(8'h00, a); chk(a, 1, "R9", "ack bit while idle");
      check_cfg("R9");

      tick(20);
      chk(exp_q.size(), 0, "R4", "scoreboard drained");
      summary();
   end

endmodule